// File: doc/BRIEF.md
# Word and Doubleword Shift Unit

A purely combinational shifter for a 64-bit integer datapath. It covers three shift kinds: left logical, right logical and right arithmetic. Each kind comes in two sizes. A word shift works on the low half of the operand and then sign-extends the 32-bit result from bit 31 across the upper half. A doubleword shift works on all 64 bits and has no sign extension.

The shift amount comes from one of three places. It can be a 5-bit immediate. It can be that immediate plus 32, which lets an immediate doubleword shift reach amounts 32 to 63. It can be the low bits of a second register operand: 5 bits for word shifts and 6 bits for doubleword shifts. A 4-bit operation code picks the kind, the size and the amount source. The unit sits in an execute stage next to the adder. Decode, register reads and forwarding stay outside it.

Top module: `dw_shift_unit`

## Requirements
- R1: Code 0 shifts bits 31:0 of the operand left by the immediate. Zeros enter at bit 0, and bits 63:32 of the result copy bit 31 of the shifted word.
- R2: Code 1 shifts bits 31:0 right by the immediate with zeros entering at bit 31. The 32-bit result is then sign-extended from its bit 31.
- R3: Code 2 shifts bits 31:0 right by the immediate. Copies of operand bit 31 enter from the top, and the result is sign-extended to 64 bits.
- R4: Codes 3, 4 and 5 perform the left, logical-right and arithmetic-right word shifts. Their amount is bits 4:0 of the shift-source register, and bits 63:5 of that register have no effect.
- R5: Code 6 shifts all 64 operand bits left by the immediate (0 to 31), with no sign extension.
- R6: Codes 9, 10 and 11 perform doubleword left, logical-right and arithmetic-right shifts by 32 plus the immediate (32 to 63).
- R7: Codes 12, 13 and 14 perform doubleword left, logical-right and arithmetic-right shifts. Their amount is bits 5:0 of the shift-source register, and bits 63:6 of that register have no effect.
- R8: Codes 7 and 8 shift all 64 bits right by the immediate. Code 7 fills with zeros. Code 8 fills with copies of operand bit 63.
- R9: An effective amount of zero returns the operand unchanged for doubleword codes. For word codes it returns bits 31:0 of the operand sign-extended from bit 31.
- R10: Code 15 is unused and yields an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 64 | Value to be shifted |
| amt_src_i | input | 64 | Register whose low bits give the amount for codes 3-5 and 12-14 |
| imm_amt_i | input | 5 | Immediate amount for codes 0-2 and 6-11 |
| op_i | input | 4 | Operation code, 0 to 15 |
| result_o | output | 64 | Shifted result |

## Verification
The checker's immediate assertions assume that every input carries a defined two-state value and that the output has settled before they are evaluated. The bench therefore applies exactly one complete input vector per clock cycle, built from fixed and random values with no unknown bits. The masks in the assertions use only the immediate field, so those assertions cover only the immediate-amount codes. The register-amount codes and the amount-ignoring rules are covered by the bench's sweep, which places random junk in the unused upper bits of the shift-source register.

// File: rtl/dw_shift_unit.sv
module dw_shift_unit #(
  parameter int XLEN = 64,
  parameter int OPW  = 4
) (
  input  logic [XLEN-1:0]            opnd_i,
  input  logic [XLEN-1:0]            amt_src_i,
  input  logic [$clog2(XLEN)-2:0]    imm_amt_i,
  input  logic [OPW-1:0]             op_i,
  output logic [XLEN-1:0]            result_o
);
  localparam int HALF  = XLEN / 2;
  localparam int AW    = $clog2(XLEN);
  localparam int NCODE = 15;

  logic          valid, word, left, arith, fill;
  logic [AW-1:0] amt;
  logic [XLEN-1:0] src, pre, post, shifted;
  logic [XLEN-1:0] stg [0:AW];

  always_comb begin
    valid = (32'(op_i) < NCODE);
    left  = (op_i % 3) == 0;
    arith = (op_i % 3) == 2;
    word  = 1'b0;
    amt   = '0;
    case (op_i / 3)
      0: begin word = 1'b1; amt = {1'b0, imm_amt_i}; end
      1: begin word = 1'b1; amt = {1'b0, amt_src_i[AW-2:0]}; end
      2: amt = {1'b0, imm_amt_i};
      3: amt = {1'b1, imm_amt_i};
      default: amt = amt_src_i[AW-1:0];
    endcase
  end

  assign src  = word ? {{HALF{arith & opnd_i[HALF-1]}}, opnd_i[HALF-1:0]} : opnd_i;
  assign fill = arith & src[XLEN-1];

  genvar i, k;
  generate
    for (i = 0; i < XLEN; i++) begin : g_rev
      assign pre[i]  = left ? src[XLEN-1-i] : src[i];
      assign post[i] = left ? stg[AW][XLEN-1-i] : stg[AW][i];
    end
  endgenerate

  assign stg[0] = pre;

  generate
    for (k = 0; k < AW; k++) begin : g_stage
      localparam int S = 1 << k;
      assign stg[k+1] = amt[k] ? {{S{fill}}, stg[k][XLEN-1:S]} : stg[k];
    end
  endgenerate

  assign shifted  = post;
  assign result_o = !valid ? '0
                  : word   ? {{HALF{shifted[HALF-1]}}, shifted[HALF-1:0]}
                  :          shifted;
endmodule

// File: rtl/dw_shift_unit_chk.sv
module dw_shift_unit_chk #(
  parameter int XLEN = 64,
  parameter int OPW  = 4
) (
  input logic [XLEN-1:0]         opnd_i,
  input logic [XLEN-1:0]         amt_src_i,
  input logic [$clog2(XLEN)-2:0] imm_amt_i,
  input logic [OPW-1:0]          op_i,
  input logic [XLEN-1:0]         result_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] low_mask, high_mask;
  assign low_mask  = (XLEN'(1) << imm_amt_i) - XLEN'(1);
  assign high_mask = ~({XLEN{1'b1}} >> imm_amt_i);

  always_comb begin
    if (op_i <= OPW'(5))
      a_r1_word_sext: assert (result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}});
    if (op_i == OPW'(0))
      a_r1_low_zero: assert ((result_o & low_mask) == '0);
    if (op_i == OPW'(7))
      a_r8_dsrl_top_zero: assert ((result_o & high_mask) == '0);
    if (op_i == OPW'(8))
      a_r8_dsra_sign: assert (result_o[XLEN-1] == opnd_i[XLEN-1]);
    if (op_i == OPW'(6) && imm_amt_i == '0)
      a_r9_zero_pass: assert (result_o == opnd_i);
    if (op_i == OPW'(15))
      a_r10_bad_code_zero: assert (result_o == '0);
  end

  logic unused_ok;
  assign unused_ok = ^amt_src_i;
endmodule

bind dw_shift_unit dw_shift_unit_chk #(.XLEN(XLEN), .OPW(OPW)) u_chk (
  .opnd_i(opnd_i), .amt_src_i(amt_src_i), .imm_amt_i(imm_amt_i),
  .op_i(op_i), .result_o(result_o)
);

// File: tb/test_dw_shift_unit.sv
module test_dw_shift_unit;
  logic        clk = 1'b0;
  logic [63:0] opnd, amt_src, res;
  logic [4:0]  imm;
  logic [3:0]  op;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dw_shift_unit i_dw_shift_unit (
    .opnd_i(opnd), .amt_src_i(amt_src), .imm_amt_i(imm), .op_i(op), .result_o(res)
  );

  function automatic logic [63:0] model(int code, logic [63:0] a, int s);
    logic [31:0] w, r32;
    logic signed [31:0] sw;
    logic signed [63:0] sa;
    if (code == 15) return 64'd0;
    if (code < 6) begin
      w = a[31:0];
      sw = w;
      case (code % 3)
        0: r32 = w << s;
        1: r32 = w >> s;
        default: r32 = 32'(sw >>> s);
      endcase
      return {{32{r32[31]}}, r32};
    end
    sa = a;
    case (code % 3)
      0: return a << s;
      1: return a >> s;
      default: return 64'(sa >>> s);
    endcase
  endfunction

  function automatic string tag(int code, int s);
    if (code == 15) return "R10";
    if (s == 0) return "R9";
    case (code)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3, 4, 5: return "R4";
      6: return "R5";
      7, 8: return "R8";
      9, 10, 11: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    opnd = '0; amt_src = '0; imm = '0; op = '0;
    for (int code = 0; code < 16; code++) begin
      for (int a = 0; a < 64; a++) begin
        for (int v = 0; v < 6; v++) begin
          logic [63:0] exp_v;
          int s;
          @(posedge clk);
          op  = 4'(code);
          imm = 5'(a);
          case (v)
            0: opnd = 64'hFFFF_FFFF_FFFF_FFFF;
            1: opnd = 64'h0000_0000_8000_0001;
            2: opnd = 64'h8000_0000_7FFF_FFFE;
            default: opnd = {$urandom, $urandom};
          endcase
          amt_src = {$urandom, $urandom};
          amt_src[5:0] = 6'(a);
          case (code / 3)
            1: s = int'(amt_src[4:0]);
            3: s = 32 + int'(imm);
            4: s = int'(amt_src[5:0]);
            default: s = int'(imm);
          endcase
          exp_v = model(code, opnd, s);
          @(negedge clk);
          checks++;
          if (res !== exp_v) begin
            errors++;
            $display("FAIL %s: code %0d amount %0d opnd %h actual %h expected %h",
                     tag(code, s), code, s, opnd, res, exp_v);
          end
        end
      end
    end
    done = 1;
    finish_run();
  end
endmodule